// File: doc/BRIEF.md
# Hierarchical Interrupt Controller

This block gathers event lines from a set of leaf banks into one interrupt line for the CPU. There are four engine banks, one bank per display pipe, and a port bank, a misc bank and a power-unit bank. Every bank has 32 raw event inputs and four 32-bit registers: live status, mask, identity and enable. A rising edge on an unmasked raw input latches into the identity register. Each identity bit can hold a second occurrence of its event, so software may have to clear a bit twice before it reads zero.

Each bank drives summary bits in a master register. A bank's summary is the OR of its identity bits gated by its enable bits. The master register also holds a global enable in bit 31, which gates the CPU line. The service routine clears that enable on entry, which holds the line low while it works, and sets it again on exit. The first three engine banks each carry two engines, one in bits 15:0 and one in bits 31:16, and each half has its own summary bit. In a pipe bank, software by convention uses bit 0 for vblank, bit 1 for vsync, bit 2 for scanline, bit 4 for flip done, bits 8 to 10 for plane, sprite and cursor faults, and bit 31 for underrun. The hardware treats all 32 bits alike.

The register interface is a plain read/write strobe with a byte address. Read data appears on the cycle after the read strobe and is zero on every other cycle.

Top module: `hierIrqCtrl`

## Requirements
- R1: After reset, every mask reads 0xFFFFFFFF, every enable, identity and live register reads 0, the master register reads 0 and cpuIrq is low.
- R2: The master register sits at byte address 0x000. Engine bank i (0..3) is based at 0x100+0x10*i and pipe bank p at 0x200+0x10*p. The port, misc and power banks are based at 0x300, 0x310 and 0x320, and are banks 4+NUM_PIPES, 5+NUM_PIPES and 6+NUM_PIPES. Inside a bank the offsets are live status +0x0, mask +0x4, identity +0x8 and enable +0xC. Reads of any other or misaligned address return 0. rdata carries the value on the cycle after rdEn and is 0 otherwise. The live status register reads the raw inputs as sampled on the previous clock.
- R3: A rising edge on a raw input whose mask bit is 1 never sets the identity bit. A level that is already high when the mask bit is cleared does not latch either.
- R4: A rising edge on a raw input whose mask bit is 0 sets that identity bit at the clock edge where the high level is first sampled. Holding the input high does not latch it again.
- R5: A second unmasked edge while the identity bit is already set is queued. A write-one clear then leaves the bit at 1, and a second clear brings it to 0. A third occurrence while two are pending is dropped.
- R6: A write to the identity register clears only the bits written as 1. Bits written as 0 are unchanged.
- R7: The master summary bits are assigned as follows. Bits 0 to 5 are the low and high halves of engine banks 0, 1 and 2, in that order. Bit 6 is engine bank 3, bits 16+p are pipe p, bit 20 is port, bit 22 is misc and bit 30 is power. Each summary bit is the OR of identity AND enable over its bits.
- R8: cpuIrq is master bit 31 AND the OR of all summary bits. It goes low on the edge that writes bit 31 as 0, even while events are pending.
- R9: A master write changes only bit 31. A master read returns bit 31 as stored and the live summary bits. Reserved bits (mask 0x3700FF00 of the read value) read 0.
- R10: The shutdown sequence leaves every identity bit at 0: mask all ones, enable 0, then two write-one clears of 0xFFFFFFFF. This holds even when events were queued twice.
- R11: The southIrq input appears directly as master bit 23 and takes part in cpuIrq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rdEn |
| rawEvt | input | 32*(7+NUM_PIPES) | Raw event lines, bank b at bits 32*b+31:32*b |
| southIrq | input | 1 | South-bridge summary level |
| cpuIrq | output | 1 | Interrupt line to the CPU |

## Verification
A write or a latching edge changes the registers at the clock edge where it is sampled, and cpuIrq follows combinationally at that same edge. Read data is registered, so it shows the state from before the edge that samples rdEn, and it appears right after that edge. The bench drives inputs on the falling edge. On each rising edge it advances a behavioural model that counts the queued occurrences per bit. On the next falling edge it compares both rdata and cpuIrq with the model, which keeps every comparison aligned to that one-edge latency.

// File: rtl/intcPkg.sv
package intcPkg;
  localparam int DATA_W = 32;
  localparam int IDX_W = 4;
  localparam int ENGINE_BANKS = 4;
  localparam int SPLIT_BANKS = 3;
  localparam int OTHER_BANKS = 3;

  localparam logic [1:0] REG_LIVE   = 2'd0;
  localparam logic [1:0] REG_MASK   = 2'd1;
  localparam logic [1:0] REG_IDENT  = 2'd2;
  localparam logic [1:0] REG_ENABLE = 2'd3;

  localparam int MB_WHOLE_ENGINE = 6;
  localparam int MB_PIPE0 = 16;
  localparam int MB_PORT = 20;
  localparam int MB_MISC = 22;
  localparam int MB_SOUTH = 23;
  localparam int MB_POWER = 30;
  localparam int MB_ENABLE = 31;

  typedef struct packed {
    logic              wrMaster;
    logic              rdMaster;
    logic              wrBank;
    logic              rdBank;
    logic [1:0]        regSel;
    logic [IDX_W-1:0]  bankIdx;
    logic [DATA_W-1:0] wdata;
  } intcStrobe_t;
endpackage

// File: rtl/intcBank.sv
module intcBank
  import intcPkg::*;
#(
  parameter int SUM_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] raw,
  input  logic              wrMask,
  input  logic              wrIdent,
  input  logic              wrEnable,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        regSel,
  output logic [DATA_W-1:0] rdVal,
  output logic [SUM_W-1:0]  summary
);
  logic [DATA_W-1:0] rawQ, maskQ, identQ, pendQ, enQ;
  logic [DATA_W-1:0] capture, clr, identD, pendD, live;

  always_comb begin
    capture = raw & ~rawQ & ~maskQ;
    clr     = wrIdent ? wdata : '0;
    identD  = (identQ & ~clr) | (pendQ & clr) | capture;
    pendD   = (clr & pendQ & capture) | (~clr & (pendQ | (identQ & capture)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ   <= '0;
      maskQ  <= '1;
      identQ <= '0;
      pendQ  <= '0;
      enQ    <= '0;
    end else begin
      rawQ   <= raw;
      identQ <= identD;
      pendQ  <= pendD;
      if (wrMask)   maskQ <= wdata;
      if (wrEnable) enQ   <= wdata;
    end
  end

  assign live = identQ & enQ;

  if (SUM_W == 2) begin : gHalves
    assign summary = {|live[DATA_W-1:DATA_W/2], |live[DATA_W/2-1:0]};
  end else begin : gWhole
    assign summary = |live;
  end

  always_comb begin
    case (regSel)
      REG_LIVE:  rdVal = rawQ;
      REG_MASK:  rdVal = maskQ;
      REG_IDENT: rdVal = identQ;
      default:   rdVal = enQ;
    endcase
  end

  // R3: no identity bit rises where the mask was set
  a_r3_masked_no_latch: assert property (@(posedge clk) disable iff (!rstN)
    ((identQ & ~$past(identQ) & $past(maskQ)) == '0));

  // R5: a queued second occurrence only exists behind a set identity bit
  a_r5_queue_behind_ident: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~identQ) == '0));

  // R6: bits written as zero never fall
  a_r6_zero_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    wrIdent |=> (($past(identQ) & ~$past(wdata) & ~identQ) == '0));
endmodule

// File: rtl/intcCtrl.sv
module intcCtrl
  import intcPkg::*;
#(
  parameter int NUM_PIPES = 3,
  parameter int ADDR_W = 12
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output intcStrobe_t       strb
);
  localparam int REGION_W = ADDR_W - 8;

  logic [REGION_W-1:0] region;
  logic [IDX_W-1:0]    slot;
  logic                hitMaster, hitBank;
  logic [IDX_W-1:0]    idx;

  assign region = addr[ADDR_W-1:8];
  assign slot   = addr[7:4];

  always_comb begin
    hitMaster = 1'b0;
    hitBank   = 1'b0;
    idx       = '0;
    if (addr[1:0] == 2'b00) begin
      if (region == REGION_W'(0)) begin
        hitMaster = (addr[7:2] == 6'd0);
      end else if (region == REGION_W'(1)) begin
        if (slot < IDX_W'(ENGINE_BANKS)) begin
          hitBank = 1'b1;
          idx     = slot;
        end
      end else if (region == REGION_W'(2)) begin
        if (slot < IDX_W'(NUM_PIPES)) begin
          hitBank = 1'b1;
          idx     = IDX_W'(ENGINE_BANKS) + slot;
        end
      end else if (region == REGION_W'(3)) begin
        if (slot < IDX_W'(OTHER_BANKS)) begin
          hitBank = 1'b1;
          idx     = IDX_W'(ENGINE_BANKS + NUM_PIPES) + slot;
        end
      end
    end
  end

  always_comb begin
    strb.wrMaster = wrEn & hitMaster;
    strb.rdMaster = rdEn & hitMaster;
    strb.wrBank   = wrEn & hitBank;
    strb.rdBank   = rdEn & hitBank;
    strb.regSel   = addr[3:2];
    strb.bankIdx  = idx;
    strb.wdata    = wdata;
  end
endmodule

// File: rtl/intcDatapath.sv
module intcDatapath
  import intcPkg::*;
#(
  parameter int NUM_PIPES = 3,
  localparam int NUM_BANKS = ENGINE_BANKS + NUM_PIPES + OTHER_BANKS,
  localparam int WHOLE_BANKS = NUM_BANKS - SPLIT_BANKS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  intcStrobe_t                 strb,
  input  logic [NUM_BANKS*DATA_W-1:0] rawEvt,
  input  logic                        southIrq,
  output logic [DATA_W-1:0]           rdata,
  output logic                        cpuIrq
);
  logic                     masterEn;
  logic [2*SPLIT_BANKS-1:0] sumSplit;
  logic [WHOLE_BANKS-1:0]   sumWhole;
  logic [DATA_W-1:0]        bankRd [NUM_BANKS];
  logic [NUM_BANKS-1:0]     bankSel;
  logic [MB_ENABLE-1:0]     summ;
  logic [DATA_W-1:0]        rdNext;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic wrM, wrI, wrE;
    assign bankSel[g] = (strb.bankIdx == IDX_W'(g));
    assign wrM = strb.wrBank & bankSel[g] & (strb.regSel == REG_MASK);
    assign wrI = strb.wrBank & bankSel[g] & (strb.regSel == REG_IDENT);
    assign wrE = strb.wrBank & bankSel[g] & (strb.regSel == REG_ENABLE);
    if (g < SPLIT_BANKS) begin : gSplit
      intcBank #(.SUM_W(2)) uBank (
        .clk(clk), .rstN(rstN), .raw(rawEvt[g*DATA_W +: DATA_W]),
        .wrMask(wrM), .wrIdent(wrI), .wrEnable(wrE), .wdata(strb.wdata),
        .regSel(strb.regSel), .rdVal(bankRd[g]), .summary(sumSplit[2*g +: 2])
      );
    end else begin : gOne
      intcBank #(.SUM_W(1)) uBank (
        .clk(clk), .rstN(rstN), .raw(rawEvt[g*DATA_W +: DATA_W]),
        .wrMask(wrM), .wrIdent(wrI), .wrEnable(wrE), .wdata(strb.wdata),
        .regSel(strb.regSel), .rdVal(bankRd[g]), .summary(sumWhole[g-SPLIT_BANKS])
      );
    end
  end

  always_comb begin
    summ = '0;
    summ[2*SPLIT_BANKS-1:0] = sumSplit;
    summ[MB_WHOLE_ENGINE]   = sumWhole[0];
    for (int p = 0; p < NUM_PIPES; p++) begin
      summ[MB_PIPE0+p] = sumWhole[1+p];
    end
    summ[MB_PORT]  = sumWhole[1+NUM_PIPES];
    summ[MB_MISC]  = sumWhole[2+NUM_PIPES];
    summ[MB_POWER] = sumWhole[3+NUM_PIPES];
    summ[MB_SOUTH] = southIrq;
  end

  assign cpuIrq = masterEn & (|summ);

  always_comb begin
    rdNext = '0;
    if (strb.rdMaster) begin
      rdNext = {masterEn, summ};
    end else if (strb.rdBank) begin
      for (int g = 0; g < NUM_BANKS; g++) begin
        if (bankSel[g]) rdNext = rdNext | bankRd[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterEn <= 1'b0;
      rdata    <= '0;
    end else begin
      rdata <= rdNext;
      if (strb.wrMaster) masterEn <= strb.wdata[MB_ENABLE];
    end
  end

  // R8: writing the global enable as zero drops the line on the next cycle
  a_r8_enable_off_drops: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMaster && !strb.wdata[MB_ENABLE]) |=> !cpuIrq);

  // R9: reserved master bits always read as zero
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.rdMaster) |-> ((rdata & 32'h3700_FF00) == '0));

  // R11: an enabled controller raises the line for the south-bridge input
  a_r11_south_raises: assert property (@(posedge clk) disable iff (!rstN)
    (masterEn && southIrq) |-> cpuIrq);
endmodule

// File: rtl/hierIrqCtrl.sv
module hierIrqCtrl
  import intcPkg::*;
#(
  parameter int NUM_PIPES = 3,
  parameter int ADDR_W = 12,
  localparam int NUM_BANKS = ENGINE_BANKS + NUM_PIPES + OTHER_BANKS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic [NUM_BANKS*DATA_W-1:0] rawEvt,
  input  logic                        southIrq,
  output logic                        cpuIrq
);
  intcStrobe_t strb;

  intcCtrl #(.NUM_PIPES(NUM_PIPES), .ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata), .strb(strb)
  );

  intcDatapath #(.NUM_PIPES(NUM_PIPES)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rawEvt(rawEvt),
    .southIrq(southIrq), .rdata(rdata), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/hierIrqCtrl_test.sv
module hierIrqCtrl_test;
  localparam int NP = 3;
  localparam int NB = 7 + NP;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic southIrq = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NB*32-1:0] rawEvt = '0;
  wire [31:0] rdata;
  wire cpuIrq;

  always #5 clk = ~clk;

  hierIrqCtrl #(.NUM_PIPES(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rawEvt(rawEvt), .southIrq(southIrq),
    .cpuIrq(cpuIrq)
  );

  int nChecks = 0;
  int nFails = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  logic [31:0] mMask [NB];
  logic [31:0] mEnab [NB];
  logic [31:0] mRawPrev [NB];
  int mCnt [NB][32];
  logic mEn;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] identVal(input int b);
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) v[i] = (mCnt[b][i] > 0);
    return v;
  endfunction

  function automatic logic [31:0] mSummary();
    logic [31:0] s = '0;
    logic [31:0] lv;
    for (int b = 0; b < NB; b++) begin
      lv = identVal(b) & mEnab[b];
      if (b < 3) begin
        s[2*b]   = |lv[15:0];
        s[2*b+1] = |lv[31:16];
      end else if (b == 3) s[6] = |lv;
      else if (b < 4 + NP) s[16 + b - 4] = |lv;
      else if (b == 4 + NP) s[20] = |lv;
      else if (b == 5 + NP) s[22] = |lv;
      else s[30] = |lv;
    end
    s[23] = southIrq;
    return s;
  endfunction

  function automatic void decode(input logic [AW-1:0] a, output int kind,
                                 output int bank, output int sel);
    int region = int'(a[11:8]);
    int idx = int'(a[7:4]);
    kind = 0; bank = 0; sel = int'(a[3:2]);
    if (a[1:0] != 2'b00) return;
    if (region == 0 && a[7:2] == 6'd0) kind = 1;
    else if (region == 1 && idx < 4) begin kind = 2; bank = idx; end
    else if (region == 2 && idx < NP) begin kind = 2; bank = 4 + idx; end
    else if (region == 3 && idx < 3) begin kind = 2; bank = 4 + NP + idx; end
  endfunction

  function automatic logic [31:0] bankAddr(input int b, input int sel);
    int base;
    if (b < 4) base = 'h100 + 'h10 * b;
    else if (b < 4 + NP) base = 'h200 + 'h10 * (b - 4);
    else base = 'h300 + 'h10 * (b - 4 - NP);
    return 32'(base + 4 * sel);
  endfunction

  task automatic tick();
    int kind, bank, sel;
    logic [31:0] expRd, rise, s;
    @(posedge clk);
    decode(addr, kind, bank, sel);
    expRd = '0;
    if (rdEn) begin
      if (kind == 1) begin
        s = mSummary();
        expRd = {mEn, s[30:0]};
      end else if (kind == 2) begin
        case (sel)
          0: expRd = mRawPrev[bank];
          1: expRd = mMask[bank];
          2: expRd = identVal(bank);
          default: expRd = mEnab[bank];
        endcase
      end
    end
    for (int b = 0; b < NB; b++) begin
      rise = rawEvt[b*32 +: 32] & ~mRawPrev[b];
      for (int i = 0; i < 32; i++) begin
        if (wrEn && kind == 2 && bank == b && sel == 2 && wdata[i] && mCnt[b][i] > 0)
          mCnt[b][i]--;
        if (rise[i] && !mMask[b][i] && mCnt[b][i] < 2) mCnt[b][i]++;
      end
      mRawPrev[b] = rawEvt[b*32 +: 32];
      if (wrEn && kind == 2 && bank == b && sel == 1) mMask[b] = wdata;
      if (wrEn && kind == 2 && bank == b && sel == 3) mEnab[b] = wdata;
    end
    if (wrEn && kind == 1) mEn = wdata[31];
    @(negedge clk);
    check(rdata, expRd, "rdata vs model");
    check({31'b0, cpuIrq}, {31'b0, mEn & (|mSummary())}, "cpuIrq vs model");
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    addr = a[AW-1:0]; wdata = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp);
    addr = a[AW-1:0]; rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
    check(rdata, exp, "read value");
  endtask

  task automatic setRaw(input int b, input logic [31:0] v);
    rawEvt[b*32 +: 32] = v;
    tick();
  endtask

  task automatic pulse(input int b, input logic [31:0] v);
    setRaw(b, v);
    setRaw(b, 32'h0);
  endtask

  task automatic expIrq(input logic v);
    check({31'b0, cpuIrq}, {31'b0, v}, "cpuIrq level");
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      mMask[b] = '1; mEnab[b] = '0; mRawPrev[b] = '0;
      for (int i = 0; i < 32; i++) mCnt[b][i] = 0;
    end
    mEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    curReq = "R1";
    rd(32'h000, 32'h0);
    rd(bankAddr(0, 1), 32'hFFFF_FFFF);
    rd(bankAddr(0, 2), 32'h0);
    rd(bankAddr(0, 3), 32'h0);
    rd(bankAddr(NB - 1, 1), 32'hFFFF_FFFF);
    rd(bankAddr(6, 0), 32'h0);
    expIrq(1'b0);

    curReq = "R2";
    wr(bankAddr(5, 3), 32'h1234_5678);
    rd(bankAddr(5, 3), 32'h1234_5678);
    wr(bankAddr(NB - 1, 1), 32'hA5A5_0F0F);
    rd(bankAddr(NB - 1, 1), 32'hA5A5_0F0F);
    rd(32'h140, 32'h0);
    rd(32'h102, 32'h0);
    rd(32'h230, 32'h0);
    rd(32'h330, 32'h0);
    setRaw(1, 32'h0000_8001);
    rd(bankAddr(1, 0), 32'h0000_8001);
    setRaw(1, 32'h0);
    wr(bankAddr(5, 3), 32'h0);
    wr(bankAddr(NB - 1, 1), 32'hFFFF_FFFF);

    curReq = "R3";
    setRaw(4, 32'h1);
    rd(bankAddr(4, 2), 32'h0);
    wr(bankAddr(4, 1), ~32'h1);
    rd(bankAddr(4, 2), 32'h0);

    curReq = "R4";
    setRaw(4, 32'h0);
    setRaw(4, 32'h1);
    rd(bankAddr(4, 2), 32'h1);
    wr(bankAddr(4, 2), 32'h1);
    rd(bankAddr(4, 2), 32'h0);
    setRaw(4, 32'h0);

    curReq = "R5";
    wr(bankAddr(4, 1), ~32'h11);
    pulse(4, 32'h10);
    pulse(4, 32'h11);
    pulse(4, 32'h10);
    rd(bankAddr(4, 2), 32'h11);
    wr(bankAddr(4, 2), 32'h10);
    rd(bankAddr(4, 2), 32'h11);
    wr(bankAddr(4, 2), 32'h10);
    rd(bankAddr(4, 2), 32'h01);
    wr(bankAddr(4, 2), 32'h10);
    rd(bankAddr(4, 2), 32'h01);

    curReq = "R6";
    wr(bankAddr(4, 2), 32'h0);
    rd(bankAddr(4, 2), 32'h01);
    wr(bankAddr(4, 2), 32'hFFFF_FFFE);
    rd(bankAddr(4, 2), 32'h01);
    wr(bankAddr(4, 2), 32'h1);
    rd(bankAddr(4, 2), 32'h0);

    curReq = "R7";
    wr(bankAddr(0, 1), 32'h0);
    wr(bankAddr(0, 3), 32'h0001_0001);
    pulse(0, 32'h0001_0000);
    rd(32'h000, 32'h0000_0002);
    expIrq(1'b0);
    pulse(0, 32'h0000_0001);
    rd(32'h000, 32'h0000_0003);
    wr(bankAddr(5, 1), 32'h0);
    wr(bankAddr(5, 3), 32'h8000_0000);
    pulse(5, 32'h8000_0000);
    rd(32'h000, 32'h0002_0003);
    wr(bankAddr(3, 1), 32'h0);
    pulse(3, 32'h4);
    rd(32'h000, 32'h0002_0003);
    wr(bankAddr(3, 3), 32'h4);
    rd(32'h000, 32'h0002_0043);

    curReq = "R8";
    wr(32'h000, 32'h8000_0000);
    expIrq(1'b1);
    wr(32'h000, 32'h0);
    expIrq(1'b0);
    rd(32'h000, 32'h0002_0043);
    wr(32'h000, 32'h8000_0000);
    expIrq(1'b1);
    wr(bankAddr(0, 2), 32'hFFFF_FFFF);
    wr(bankAddr(5, 2), 32'hFFFF_FFFF);
    expIrq(1'b1);
    wr(bankAddr(3, 2), 32'hFFFF_FFFF);
    expIrq(1'b0);

    curReq = "R9";
    wr(32'h000, 32'hFFFF_FFFF);
    rd(32'h000, 32'h8000_0000);
    wr(32'h000, 32'h7FFF_FFFF);
    rd(32'h000, 32'h0);

    curReq = "R11";
    southIrq = 1'b1;
    tick();
    rd(32'h000, 32'h0080_0000);
    expIrq(1'b0);
    wr(32'h000, 32'h8000_0000);
    expIrq(1'b1);
    southIrq = 1'b0;
    tick();
    expIrq(1'b0);

    curReq = "R10";
    wr(bankAddr(NB - 1, 1), 32'h0);
    wr(bankAddr(NB - 1, 3), 32'hFFFF_FFFF);
    pulse(NB - 1, 32'hF00F_000F);
    pulse(NB - 1, 32'hF00F_000F);
    expIrq(1'b1);
    rd(32'h000, 32'hC000_0000);
    wr(bankAddr(NB - 1, 1), 32'hFFFF_FFFF);
    wr(bankAddr(NB - 1, 3), 32'h0);
    expIrq(1'b0);
    wr(bankAddr(NB - 1, 2), 32'hFFFF_FFFF);
    rd(bankAddr(NB - 1, 2), 32'hF00F_000F);
    wr(bankAddr(NB - 1, 2), 32'hFFFF_FFFF);
    rd(bankAddr(NB - 1, 2), 32'h0);
    pulse(NB - 1, 32'hFFFF_FFFF);
    rd(bankAddr(NB - 1, 2), 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL %s watchdog expired actual 1 expected 0", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule